// File: doc/BRIEF.md
# Low-Randomness Masked AND Gate

This block computes the AND of two secret bits held in Boolean-shared form. Each operand arrives as `ORD+1` shares whose XOR is the secret value. The result leaves as `ORD+1` fresh shares whose XOR is the product. `ORD` is the protection order and is set by a parameter. The block is meant to be the non-linear cell inside a side-channel hardened datapath, for example a masked S-box. The cell next to it supplies fresh random bits in parallel with every operation.

Products with equal share index go straight to their own output share. Cross-share products are handled in sub-blocks, and `ORD mod 4` selects which ones are built. Each group of four cross offsets becomes a five-stage ordered chain that uses one random vector as a mask and then the same vector rotated by one share. The leftover offsets become a shorter chain, a pair of single-cycle remasking stages, or a reuse trick for order two. The gate needs roughly `ORD(ORD+1)/4` fresh bits per operation.

To keep the sub-blocks aligned, the operand shares and random bits are delayed rather than the partial products. Each sub-block taps the delay line at the depth that makes its result arrive at the common output cycle. The gate accepts one operation per cycle.

Top module: `msk_and_gate`

## Requirements
- R1: While reset is asserted, and after its release until a valid operation has traversed the pipeline, `out_vld_o` is 0.
- R2: An operation accepted with `in_vld_i`=1 produces `out_vld_o`=1 exactly LAT cycles later. LAT is 5 for ORD≥4, 4 for ORD=3, 2 for ORD=2, 1 for ORD=1 and 0 for ORD=0. Back-to-back operations give back-to-back results in order.
- R3: For every sharing of the operands and every value of `rnd_i`, the XOR of all bits of `q_sh_o` equals (XOR of `a_sh_i`) AND (XOR of `b_sh_i`) of the matching operation.
- R4: `rnd_i` carries floor(ORD/4)·(ORD+1) bits plus the bits of the last partial group. For ORD=1..5 the totals are 1, 2, 4, 5 and 9. For ORD=0 the port is one bit wide and unused.
- R5: For ORD≥4, with the operand shares fixed, flipping bit j (0≤j≤ORD) of `rnd_i` flips exactly output shares j and (j−1) mod (ORD+1).
- R6: For ORD mod 4 = 1, with the operand shares fixed, flipping `rnd_i` bit floor(ORD/4)·(ORD+1)+h, for h < (ORD+1)/2, flips exactly output shares h and h+(ORD+1)/2.
- R7: When no operation is in flight, `q_sh_o` holds its value and the values on `a_sh_i`, `b_sh_i` and `rnd_i` have no effect on it.
- R8: For ORD=0 the gate is a plain combinational AND: `q_sh_o` = `a_sh_i` & `b_sh_i` and `out_vld_o` = `in_vld_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld_i | input | 1 | Operation strobe |
| a_sh_i | input | ORD+1 | Shares of operand a |
| b_sh_i | input | ORD+1 | Shares of operand b |
| rnd_i | input | max(1, RW) | Fresh random bits for this operation |
| q_sh_o | output | ORD+1 | Shares of a AND b |
| out_vld_o | output | 1 | Result strobe |

## Verification
The assertions assume that every random bit is supplied together with its operation's strobe. They also assume that the operand shares stay as given while that strobe is high. With these assumptions the unshared result LAT cycles later depends only on the operands. The hold property assumes that nothing needs to move while no strobe is inside the pipeline. The stimulus follows this: the strobe is raised only together with a complete sharing and random word. While the strobe is low, the inputs are filled with unrelated values, so that any leak into the result would show.

// File: rtl/msk_pkg.sv
package msk_pkg;

  // fresh random bits needed for a given protection order
  function automatic int rnd_bits(input int ord);
    int n;
    int tot;
    n   = ord + 1;
    tot = (ord / 4) * n;
    case (ord % 4)
      1: tot = tot + n / 2;
      2: tot = tot + ((ord == 2) ? 2 : n);
      3: tot = tot + n;
      default: tot = tot + 0;
    endcase
    return tot;
  endfunction

  // cycles from input strobe to output strobe
  function automatic int pipe_lat(input int ord);
    if (ord >= 4)      return 5;
    else if (ord == 3) return 4;
    else if (ord == 2) return 2;
    else if (ord == 1) return 1;
    else               return 0;
  endfunction

  // number of cross-term sub-blocks
  function automatic int num_blk(input int ord);
    return (ord / 4) + (((ord % 4) != 0) ? 1 : 0);
  endfunction

endpackage

// File: rtl/msk_rst_sync.sv
module msk_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/msk_tap_line.sv
// Delay line for operand shares, random bits and the strobe.
// Tap k holds the operation accepted k cycles earlier; tap 0 is the input.
module msk_tap_line #(
  parameter int N  = 2,
  parameter int RW = 1,
  parameter int L  = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  logic [N-1:0]         a_i,
  input  logic [N-1:0]         b_i,
  input  logic [RW-1:0]        r_i,
  output logic [L:0]           v_o,
  output logic [L:0][N-1:0]    a_o,
  output logic [L:0][N-1:0]    b_o,
  output logic [L:0][RW-1:0]   r_o
);
  generate
    if (L == 0) begin : g_wire
      assign v_o[0] = vld_i;
      assign a_o[0] = a_i;
      assign b_o[0] = b_i;
      assign r_o[0] = r_i;
    end else begin : g_regs
      logic [L-1:0]         v_q;
      logic [L-1:0]         v_d;
      logic [L-1:0][N-1:0]  a_q;
      logic [L-1:0][N-1:0]  b_q;
      logic [L-1:0][RW-1:0] r_q;
      logic [L:0]           v_all;
      logic [L:0][N-1:0]    a_all;
      logic [L:0][N-1:0]    b_all;
      logic [L:0][RW-1:0]   r_all;

      assign v_all = {v_q, vld_i};
      assign a_all = {a_q, a_i};
      assign b_all = {b_q, b_i};
      assign r_all = {r_q, r_i};

      always_comb v_d = v_all[L-1:0];

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) v_q <= '0;
        else         v_q <= v_d;
      end

      // data stages load only when an operation moves into them
      for (genvar k = 0; k < L; k++) begin : g_stage
        always_ff @(posedge clk_i) begin
          if (v_all[k]) begin
            a_q[k] <= a_all[k];
            b_q[k] <= b_all[k];
            r_q[k] <= r_all[k];
          end
        end
      end

      assign v_o = v_all;
      assign a_o = a_all;
      assign b_o = b_all;
      assign r_o = r_all;
    end
  endgenerate
endmodule

// File: rtl/msk_seq_chain.sv
// Ordered remasking chain for two cross offsets M1, M2.
// FULL=1: mask, pair at M1, rotated mask, pair at M2 (five stages).
// FULL=0: the M2 mirror term is dropped (four stages).
module msk_seq_chain #(
  parameter int N    = 5,
  parameter int M1   = 1,
  parameter int M2   = 2,
  parameter bit FULL = 1'b1,
  localparam int NT    = FULL ? 4 : 3,
  localparam int DEPTH = FULL ? 5 : 4
) (
  input  logic                  clk_i,
  input  logic [DEPTH-1:0]      en_i,
  input  logic [NT-1:0][N-1:0]  a_i,
  input  logic [NT-1:0][N-1:0]  b_i,
  input  logic [N-1:0]          r_first_i,
  input  logic [N-1:0]          r_second_i,
  output logic [N-1:0]          q_o
);
  logic [DEPTH-1:0][N-1:0] st_d;
  logic [DEPTH-1:0][N-1:0] st_q;

  always_comb begin
    st_d = '0;
    for (int i = 0; i < N; i++) begin
      st_d[0][i] = r_first_i[i] ^ (a_i[0][i] & b_i[0][(i + M1) % N]);
      st_d[1][i] = st_q[0][i] ^ (a_i[1][(i + M1) % N] & b_i[1][i]);
      st_d[2][i] = st_q[1][i] ^ r_second_i[(i + 1) % N];
      st_d[3][i] = st_q[2][i] ^ (a_i[2][i] & b_i[2][(i + M2) % N]);
      if (FULL) begin
        st_d[DEPTH-1][i] = st_q[3][i] ^ (a_i[NT-1][(i + M2) % N] & b_i[NT-1][i]);
      end
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_st
    always_ff @(posedge clk_i) begin
      if (en_i[s]) st_q[s] <= st_d[s];
    end
  end

  assign q_o = st_q[DEPTH-1];
endmodule

// File: rtl/msk_dom_cross.sv
// One cross term per share, remasked by a fresh bit and registered.
// Share i takes a_i & b_(i+OFS) masked by r[(i+RSH) mod RMOD].
module msk_dom_cross #(
  parameter int N    = 2,
  parameter int OFS  = 1,
  parameter int RSH  = 0,
  parameter int RMOD = 1
) (
  input  logic            clk_i,
  input  logic            en_i,
  input  logic [N-1:0]    a_i,
  input  logic [N-1:0]    b_i,
  input  logic [RMOD-1:0] r_i,
  output logic [N-1:0]    q_o
);
  logic [N-1:0] t_d;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      t_d[i] = r_i[(i + RSH) % RMOD] ^ (a_i[i] & b_i[(i + OFS) % N]);
    end
  end

  always_ff @(posedge clk_i) begin
    if (en_i) q_o <= t_d;
  end
endmodule

// File: rtl/msk_pair_reuse.sv
// Order-two cross terms with two random bits; the third mask is their XOR.
module msk_pair_reuse (
  input  logic                clk_i,
  input  logic [1:0]          en_i,
  input  logic [1:0][2:0]     a_i,
  input  logic [1:0][2:0]     b_i,
  input  logic [1:0]          r_i,
  output logic [2:0]          q_o
);
  logic [2:0] z;
  logic [2:0] s0_d;
  logic [2:0] s0_q;
  logic [2:0] s1_d;

  assign z = {r_i[0] ^ r_i[1], r_i[1], r_i[0]};

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      s0_d[i] = z[i] ^ (a_i[0][i] & b_i[0][(i + 1) % 3]);
      s1_d[i] = s0_q[i] ^ (a_i[1][(i + 1) % 3] & b_i[1][i]);
    end
  end

  always_ff @(posedge clk_i) begin
    if (en_i[0]) s0_q <= s0_d;
  end

  always_ff @(posedge clk_i) begin
    if (en_i[1]) q_o <= s1_d;
  end
endmodule

// File: rtl/msk_and_gate.sv
module msk_and_gate
  import msk_pkg::*;
#(
  parameter int ORD = 5,
  localparam int NSH = ORD + 1,
  localparam int RW  = rnd_bits(ORD),
  localparam int RWP = (RW > 0) ? RW : 1,
  localparam int LAT = pipe_lat(ORD)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           in_vld_i,
  input  logic [NSH-1:0] a_sh_i,
  input  logic [NSH-1:0] b_sh_i,
  input  logic [RWP-1:0] rnd_i,
  output logic [NSH-1:0] q_sh_o,
  output logic           out_vld_o
);
  localparam int NCOMP = ORD / 4;
  localparam int NBLK  = num_blk(ORD);
  localparam int NBA   = (NBLK > 0) ? NBLK : 1;
  localparam int LOFS  = NCOMP * NSH;   // first random bit of the last group
  localparam int LM1   = 2 * NCOMP + 1;
  localparam int LM2   = 2 * NCOMP + 2;

  logic                      rst_sync_n;
  logic [LAT:0]              v_tap;
  logic [LAT:0][NSH-1:0]     a_tap;
  logic [LAT:0][NSH-1:0]     b_tap;
  logic [LAT:0][RWP-1:0]     r_tap;
  logic [NBA-1:0][NSH-1:0]   blk_q;
  logic [NSH-1:0]            q_acc;

  msk_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  msk_tap_line #(.N(NSH), .RW(RWP), .L(LAT)) u_taps (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .vld_i  (in_vld_i),
    .a_i    (a_sh_i),
    .b_i    (b_sh_i),
    .r_i    (rnd_i),
    .v_o    (v_tap),
    .a_o    (a_tap),
    .b_o    (b_tap),
    .r_o    (r_tap)
  );

  generate
    if (NBLK == 0) begin : g_none
      assign blk_q[0] = '0;
    end

    // full groups of four cross offsets
    for (genvar k = 0; k < NCOMP; k++) begin : g_full
      localparam int T0 = LAT - 5;
      logic [3:0][NSH-1:0] ca;
      logic [3:0][NSH-1:0] cb;
      for (genvar p = 0; p < 4; p++) begin : g_term
        assign ca[p] = a_tap[T0 + ((p < 2) ? p : p + 1)];
        assign cb[p] = b_tap[T0 + ((p < 2) ? p : p + 1)];
      end
      msk_seq_chain #(.N(NSH), .M1(2*k+1), .M2(2*k+2), .FULL(1'b1)) u_chain (
        .clk_i      (clk_i),
        .en_i       (v_tap[T0 +: 5]),
        .a_i        (ca),
        .b_i        (cb),
        .r_first_i  (r_tap[T0][k*NSH +: NSH]),
        .r_second_i (r_tap[T0 + 2][k*NSH +: NSH]),
        .q_o        (blk_q[k])
      );
    end

    // last partial group, chosen by ORD mod 4
    if (ORD % 4 == 3) begin : g_three
      localparam int T0 = LAT - 4;
      logic [2:0][NSH-1:0] ca;
      logic [2:0][NSH-1:0] cb;
      for (genvar p = 0; p < 3; p++) begin : g_term
        assign ca[p] = a_tap[T0 + ((p < 2) ? p : p + 1)];
        assign cb[p] = b_tap[T0 + ((p < 2) ? p : p + 1)];
      end
      msk_seq_chain #(.N(NSH), .M1(LM1), .M2(LM2), .FULL(1'b0)) u_chain (
        .clk_i      (clk_i),
        .en_i       (v_tap[T0 +: 4]),
        .a_i        (ca),
        .b_i        (cb),
        .r_first_i  (r_tap[T0][LOFS +: NSH]),
        .r_second_i (r_tap[T0 + 2][LOFS +: NSH]),
        .q_o        (blk_q[NCOMP])
      );
    end else if (ORD == 2) begin : g_reuse
      localparam int T0 = LAT - 2;
      msk_pair_reuse u_reuse (
        .clk_i (clk_i),
        .en_i  (v_tap[T0 +: 2]),
        .a_i   ({a_tap[T0 + 1], a_tap[T0]}),
        .b_i   ({b_tap[T0 + 1], b_tap[T0]}),
        .r_i   (r_tap[T0][1:0]),
        .q_o   (blk_q[NCOMP])
      );
    end else if (ORD % 4 == 2) begin : g_two
      localparam int T0 = LAT - 1;
      logic [NSH-1:0] qa;
      logic [NSH-1:0] qb;
      msk_dom_cross #(.N(NSH), .OFS(LM1), .RSH(0), .RMOD(NSH)) u_lo (
        .clk_i (clk_i),
        .en_i  (v_tap[T0]),
        .a_i   (a_tap[T0]),
        .b_i   (b_tap[T0]),
        .r_i   (r_tap[T0][LOFS +: NSH]),
        .q_o   (qa)
      );
      msk_dom_cross #(.N(NSH), .OFS(LM2), .RSH(LM2), .RMOD(NSH)) u_hi (
        .clk_i (clk_i),
        .en_i  (v_tap[T0]),
        .a_i   (a_tap[T0]),
        .b_i   (b_tap[T0]),
        .r_i   (r_tap[T0][LOFS +: NSH]),
        .q_o   (qb)
      );
      assign blk_q[NCOMP] = qa ^ qb;
    end else if (ORD % 4 == 1) begin : g_one
      localparam int T0 = LAT - 1;
      msk_dom_cross #(.N(NSH), .OFS(NSH/2), .RSH(0), .RMOD(NSH/2)) u_half (
        .clk_i (clk_i),
        .en_i  (v_tap[T0]),
        .a_i   (a_tap[T0]),
        .b_i   (b_tap[T0]),
        .r_i   (r_tap[T0][LOFS +: NSH/2]),
        .q_o   (blk_q[NCOMP])
      );
    end
  endgenerate

  // inner-domain products join the registered cross results
  always_comb begin
    q_acc = a_tap[LAT] & b_tap[LAT];
    for (int k = 0; k < NBLK; k++) q_acc = q_acc ^ blk_q[k];
  end

  assign q_sh_o    = q_acc;
  assign out_vld_o = v_tap[LAT];
endmodule

// File: rtl/msk_and_chk.sv
module msk_and_chk
  import msk_pkg::*;
#(
  parameter int ORD = 5,
  localparam int NSH = ORD + 1,
  localparam int LAT = pipe_lat(ORD)
) (
  input logic           clk_i,
  input logic           rst_n,
  input logic           in_vld_i,
  input logic [NSH-1:0] a_sh_i,
  input logic [NSH-1:0] b_sh_i,
  input logic [NSH-1:0] q_sh_o,
  input logic           out_vld_o
);
  // shadow pipeline of strobe and unshared expected product
  logic [LAT:0] cv;
  logic [LAT:0] ce;
  logic         quiet;

  assign cv[0] = in_vld_i;
  assign ce[0] = (^a_sh_i) & (^b_sh_i);

  generate
    if (LAT > 0) begin : g_pipe
      always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
          cv[LAT:1] <= '0;
          ce[LAT:1] <= '0;
        end else begin
          cv[LAT:1] <= cv[LAT-1:0];
          ce[LAT:1] <= ce[LAT-1:0];
        end
      end
      assign quiet = ~(|cv[LAT-1:0]);

      // R7
      idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        $past(quiet) |-> $stable(q_sh_o));
    end else begin : g_flat
      assign quiet = 1'b0;
    end
  endgenerate

  // R1
  always @(negedge clk_i) begin
    if (!rst_n) begin
      rst_quiet_chk: assert (!out_vld_o);
    end
  end

  // R2
  lat_match_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    out_vld_o == cv[LAT]);

  // R3
  unshared_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    out_vld_o |-> ((^q_sh_o) == ce[LAT]));
endmodule

bind msk_and_gate msk_and_chk #(.ORD(ORD)) chk_i (
  .clk_i     (clk_i),
  .rst_n     (rst_sync_n),
  .in_vld_i  (in_vld_i),
  .a_sh_i    (a_sh_i),
  .b_sh_i    (b_sh_i),
  .q_sh_o    (q_sh_o),
  .out_vld_o (out_vld_o)
);

// File: tb/msk_and_gate_tb_top.sv
`timescale 1ns/1ps
module msk_and_gate_tb_top;
  localparam int ORD = 5;
  localparam int N   = 6;
  localparam int RW  = 9;   // R4: 6 + 3 for order five
  localparam int L   = 5;   // R2: latency for order five

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          in_vld = 1'b0;
  logic [N-1:0]  a_sh = '0;
  logic [N-1:0]  b_sh = '0;
  logic [RW-1:0] rnd = '0;
  logic [N-1:0]  q_sh;
  logic          out_vld;

  logic a0 = 1'b0, b0 = 1'b0, v0 = 1'b0, rnd0 = 1'b0;
  logic q0, vld0_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  bit           exp_q[$];
  logic [N-1:0] obs_q[$];

  always #2.5 clk = ~clk;

  msk_and_gate #(.ORD(ORD)) dut_i (
    .clk_i (clk), .rst_ni (rst_ni), .in_vld_i (in_vld),
    .a_sh_i (a_sh), .b_sh_i (b_sh), .rnd_i (rnd),
    .q_sh_o (q_sh), .out_vld_o (out_vld)
  );

  msk_and_gate #(.ORD(0)) dut0_i (
    .clk_i (clk), .rst_ni (rst_ni), .in_vld_i (v0),
    .a_sh_i (a0), .b_sh_i (b0), .rnd_i (rnd0),
    .q_sh_o (q0), .out_vld_o (vld0_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: pop the scoreboard whenever a result appears
  always @(negedge clk) begin
    if (rst_ni && out_vld) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "result without operation", 1, 0);
      end else begin
        bit e;
        e = exp_q.pop_front();
        check((^q_sh) == e, "R3", "unshared product", ^q_sh, e);
      end
      obs_q.push_back(q_sh);
    end
  end

  task automatic send_sh(input logic [N-1:0] as, input logic [N-1:0] bs,
                         input logic [RW-1:0] r);
    @(negedge clk);
    in_vld = 1'b1;
    a_sh   = as;
    b_sh   = bs;
    rnd    = r;
    exp_q.push_back((^as) & (^bs));
  endtask

  function automatic logic [N-1:0] share(input bit v);
    logic [N-1:0] s;
    s = N'($urandom);
    s[N-1] = (^s[N-2:0]) ^ v;
    return s;
  endfunction

  task automatic send(input bit av, input bit bv, input logic [RW-1:0] r);
    send_sh(share(av), share(bv), r);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_vld = 1'b0;
      a_sh   = N'($urandom);
      b_sh   = N'($urandom);
      rnd    = RW'($urandom);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] fa, fb, snap, d;
    int first;

    // R1: outputs quiet under reset and just after release
    repeat (3) @(negedge clk);
    check(out_vld == 1'b0, "R1", "valid in reset", out_vld, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    check(out_vld == 1'b0, "R1", "valid after release", out_vld, 0);

    // R4: random port width
    check($bits(dut_i.rnd_i) == RW, "R4", "random width", $bits(dut_i.rnd_i), RW);

    // R8: order zero is a plain AND in the same cycle
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      a0 = c[0]; b0 = c[1]; v0 = c[0] ^ c[1]; rnd0 = c[0];
      #1;
      check(q0 == (a0 & b0), "R8", "order zero product", q0, a0 & b0);
      check(vld0_o == v0, "R8", "order zero strobe", vld0_o, v0);
    end

    // R3: every operand combination with fixed random words
    for (int c = 0; c < 4; c++) begin
      send(c[0], c[1], '0);
      send(c[0], c[1], '1);
      send(c[0], c[1], RW'($urandom));
    end
    idle(L + 2);

    // R2: single operation latency
    send(1'b1, 1'b1, RW'($urandom));
    first = -1;
    for (int k = 1; k <= L + 2; k++) begin
      idle(1);
      if (out_vld && first < 0) first = k;
    end
    check(first == L, "R2", "latency", first, L);

    // R2 and R3: back-to-back burst, then gapped traffic
    for (int k = 0; k < 150; k++) send($urandom, $urandom, RW'($urandom));
    idle(L + 2);
    check(exp_q.size() == 0, "R2", "burst drained", exp_q.size(), 0);
    for (int k = 0; k < 40; k++) begin
      send($urandom, $urandom, RW'($urandom));
      idle($urandom_range(0, 6));
    end
    idle(L + 2);
    check(exp_q.size() == 0, "R2", "gapped drained", exp_q.size(), 0);

    // R7: nothing in flight, inputs toggle with strobe low
    snap = q_sh;
    for (int k = 0; k < 8; k++) begin
      idle(1);
      check(q_sh == snap, "R7", "held shares", q_sh, snap);
      check(out_vld == 1'b0, "R7", "no strobe", out_vld, 0);
    end

    // R5: random bit 2 of the full group flips shares 2 and 1
    obs_q.delete();
    fa = share(1'b1);
    fb = share(1'b0);
    send_sh(fa, fb, 9'h0a5);
    send_sh(fa, fb, 9'h0a5 ^ 9'h004);
    idle(L + 2);
    d = obs_q[1] ^ obs_q[0];
    check(d == 6'b000110, "R5", "share flip pattern", d, 6'b000110);

    // R6: random bit 7 (last group, h=1) flips shares 1 and 4
    obs_q.delete();
    fa = share(1'b1);
    fb = share(1'b1);
    send_sh(fa, fb, 9'h13c);
    send_sh(fa, fb, 9'h13c ^ 9'h080);
    idle(L + 2);
    d = obs_q[1] ^ obs_q[0];
    check(d == 6'b010010, "R6", "share flip pattern", d, 6'b010010);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule